// File: doc/BRIEF.md
# Windowed Watchdog Timer with Selectable Postscaler

This block supervises a processor from a slow, free-running oscillator tick. A fixed prescaler divides the tick. An 8-bit base counter then forms the base period, nominally 4 ms with the default prescaler. A 16-bit postscaler counts base-counter wraps. A 4-bit select picks which postscaler bit ends the period, so the period can be stretched by 1 to 32768 times in powers of two. At the top setting the period reaches about 131 s.

If software does not restart the timer in time, the block emits a one-cycle reset pulse. If the system entered sleep since its last restart, it emits a one-cycle wake pulse instead. An optional window mode also punishes restarts that come too early. A restart strobe that arrives before the base count reaches its top quarter is treated as a fault and yields a reset. A status flag tells software when the window is open.

Restart sources are the software clear strobe, a sleep-entry strobe, a change of the oscillator frequency select, and a clock-failure flag. Every counter is held at zero while the watchdog is disabled.

Top module: `guard_timer`

## Requirements
- R1: While `rst` is high and on the cycle after it, `wdt_rst`, `wdt_wake` and `win_open` are all 0, and counting starts from zero once `rst` falls.
- R2: The watchdog runs when `hw_en` or `sw_en` is 1, so `sw_en` matters only while `hw_en` is 0. While both are 0, the counters stay at zero, `win_open` stays 0, and no reset or wake pulse is produced, not even by a clear strobe in window mode.
- R3: The counters advance only on cycles with `osc_tick` high. Counted from a restart, a timeout happens on the tick numbered PRE_DIV × 2^BASE_W × 2^`period_sel`. Select value 0 means the first base-counter wrap.
- R4: Each timeout pulse is exactly one cycle long, and all counters restart from zero on the timeout cycle. The next timeout therefore follows a full period later.
- R5: `win_open` is 1 exactly when the base count is at or above three quarters of its range. For 8 bits that is 8'hC0 or greater; for 4 bits it is 12 or greater.
- R6: A high `sleep_enter`, `osc_sel_chg` or `clk_fail` on a clock edge clears the prescaler, base counter and postscaler without a pulse.
- R7: With `win_mode_n` = 0, a `kick` sampled while `win_open` is 0 gives a reset pulse on the next cycle and restarts the counters.
- R8: A `kick` sampled with `win_mode_n` = 1, or with `win_open` = 1, clears the counters without a pulse.
- R9: A timeout after a `sleep_enter` gives a `wake` pulse instead of a reset. The block then counts as awake, and a `kick` also marks it awake, so the following timeout gives a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high device reset |
| osc_tick | input | 1 | One-cycle strobe from the slow internal oscillator |
| hw_en | input | 1 | Hardware (fuse) enable; forces the watchdog on |
| sw_en | input | 1 | Software enable, effective while hw_en is 0 |
| period_sel | input | SEL_W | Postscaler select, ratio 2^period_sel |
| win_mode_n | input | 1 | Active-low window-mode enable |
| kick | input | 1 | Software clear strobe |
| sleep_enter | input | 1 | Strobe on entry to sleep; clears and arms wake |
| osc_sel_chg | input | 1 | Strobe on a change of oscillator frequency select |
| clk_fail | input | 1 | Clock-failure flag; clears while high |
| wdt_rst | output | 1 | One-cycle reset request |
| wdt_wake | output | 1 | One-cycle wake-up request |
| win_open | output | 1 | Window flag: base count in its top quarter |

## Verification
Every internal counter can be seen at the ports through one of two things: the cycle on which the reset or wake pulse appears, or the cycle on which `win_open` rises. Suppose the prescaler, base counter or postscaler holds a wrong value, or misses a clear. The pulse then moves away from its exact expected cycle within one period, or the window flag flips on the wrong cycle within one base period. Both are checked to the exact cycle after reset, after each kind of restart, and on both sides of the window boundary. A wrong sleep state shows as a swapped pulse kind on the very next timeout.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int unsigned GT_PRE_DIV = 125;
  localparam int unsigned GT_BASE_W  = 8;
  localparam int unsigned GT_POST_W  = 16;
  localparam int unsigned GT_SEL_W   = 4;

  // restart causes gathered in one word
  typedef struct packed {
    logic kick;
    logic sleep;
    logic osc;
    logic fail;
  } gt_clr_t;
endpackage

// File: rtl/gt_prescale.sv
module gt_prescale #(
  parameter int unsigned DIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic step
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_pins;
      assign unused_pins = ^{clk, rst, clr};
      assign step = tick;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || clr)
          cnt <= '0;
        else if (tick)
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      assign step = tick && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/gt_base.sv
module gt_base #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] val,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      val <= '0;
    else if (step)
      val <= val + 1'b1;
  end

  assign wrap = step && (val == {W{1'b1}});
endmodule

// File: rtl/gt_post.sv
module gt_post #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wrap,
  input  logic [SW-1:0] sel,
  output logic          expire
);
  logic [W-1:0] cnt;
  logic [W-1:0] nxt;

  assign nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (wrap)
      cnt <= nxt;
  end

  // the selected bit of the incremented count sets after 2^sel wraps
  assign expire = wrap && (int'(sel) < int'(W)) && nxt[sel];
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int unsigned PRE_DIV = GT_PRE_DIV,
  parameter int unsigned BASE_W  = GT_BASE_W,
  parameter int unsigned POST_W  = GT_POST_W,
  parameter int unsigned SEL_W   = GT_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             win_mode_n,
  input  logic             kick,
  input  logic             sleep_enter,
  input  logic             osc_sel_chg,
  input  logic             clk_fail,
  output logic             wdt_rst,
  output logic             wdt_wake,
  output logic             win_open
);
  localparam logic [BASE_W-1:0] WIN_AT = {2'b11, {(BASE_W-2){1'b0}}};

  gt_clr_t            cause;
  logic               run;
  logic               step;
  logic               wrap;
  logic               expire;
  logic [BASE_W-1:0]  base_val;
  logic               open_i;
  logic               bad_kick;
  logic               timeout;
  logic               clr;
  logic               sleeping;
  logic               rst_q;
  logic               wake_q;

  assign cause    = '{kick: kick, sleep: sleep_enter, osc: osc_sel_chg, fail: clk_fail};
  assign run      = hw_en | sw_en;
  assign open_i   = (base_val >= WIN_AT);
  assign bad_kick = run & cause.kick & ~win_mode_n & ~open_i;
  assign timeout  = run & expire & ~(|cause);
  assign clr      = ~run | (|cause) | timeout;

  gt_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .tick (osc_tick),
    .step (step)
  );

  gt_base #(.W(BASE_W)) u_base (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .step (step),
    .val  (base_val),
    .wrap (wrap)
  );

  gt_post #(.W(POST_W), .SW(SEL_W)) u_post (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .wrap   (wrap),
    .sel    (period_sel),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sleeping <= 1'b0;
      rst_q    <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      rst_q  <= bad_kick | (timeout & ~sleeping);
      wake_q <= timeout & sleeping;
      if (cause.sleep)
        sleeping <= 1'b1;
      else if (timeout || cause.kick)
        sleeping <= 1'b0;
    end
  end

  assign wdt_rst  = rst_q;
  assign wdt_wake = wake_q;
  assign win_open = open_i;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk (
  input logic clk,
  input logic rst,
  input logic hw_en,
  input logic sw_en,
  input logic kick,
  input logic win_mode_n,
  input logic sleep_enter,
  input logic osc_sel_chg,
  input logic clk_fail,
  input logic wdt_rst,
  input logic wdt_wake,
  input logic win_open
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wdt_rst && !wdt_wake && !win_open));

  assert_off_no_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !(hw_en || sw_en) |=> (!wdt_rst && !wdt_wake));

  assert_off_closed_R2: assert property (@(posedge clk) disable iff (rst)
    !(hw_en || sw_en) |=> !win_open);

  assert_wake_single_R4: assert property (@(posedge clk) disable iff (rst)
    wdt_wake |=> !wdt_wake);

  assert_restart_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (sleep_enter || osc_sel_chg || clk_fail) |=> !win_open);

  assert_early_kick_R7: assert property (@(posedge clk) disable iff (rst)
    (kick && !win_mode_n && !win_open && (hw_en || sw_en)) |=> wdt_rst);

  assert_kind_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(wdt_rst && wdt_wake));
endmodule

bind guard_timer guard_timer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .hw_en       (hw_en),
  .sw_en       (sw_en),
  .kick        (kick),
  .win_mode_n  (win_mode_n),
  .sleep_enter (sleep_enter),
  .osc_sel_chg (osc_sel_chg),
  .clk_fail    (clk_fail),
  .wdt_rst     (wdt_rst),
  .wdt_wake    (wdt_wake),
  .win_open    (win_open)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;
  localparam int PD = 2;
  localparam int BW = 4;
  localparam int PW = 16;
  localparam int SW = 4;
  localparam int BP = PD * (1 << BW);  // base period in ticks: 32

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          osc_tick = 1'b1;
  logic          hw_en = 1'b1;
  logic          sw_en = 1'b0;
  logic [SW-1:0] period_sel = '0;
  logic          win_mode_n = 1'b1;
  logic          kick = 1'b0;
  logic          sleep_enter = 1'b0;
  logic          osc_sel_chg = 1'b0;
  logic          clk_fail = 1'b0;
  logic          wdt_rst;
  logic          wdt_wake;
  logic          win_open;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  guard_timer #(.PRE_DIV(PD), .BASE_W(BW), .POST_W(PW), .SEL_W(SW)) u0 (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .hw_en(hw_en), .sw_en(sw_en),
    .period_sel(period_sel), .win_mode_n(win_mode_n), .kick(kick),
    .sleep_enter(sleep_enter), .osc_sel_chg(osc_sel_chg), .clk_fail(clk_fail),
    .wdt_rst(wdt_rst), .wdt_wake(wdt_wake), .win_open(win_open)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic measure(input int exp, input bit want_wake, input string req);
    int n = 0;
    for (int i = 1; i <= exp + 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wdt_rst || wdt_wake) begin
        n = i;
        break;
      end
    end
    check(n == exp, req, "timeout cycle", n, exp);
    check(wdt_wake == want_wake && wdt_rst == !want_wake, req,
          "pulse kind (wake)", int'(wdt_wake), int'(want_wake));
  endtask

  task automatic pulse_gone;
    cyc(1);
    check(!wdt_rst && !wdt_wake, "R4", "pulse width", int'(wdt_rst | wdt_wake), 0);
  endtask

  task automatic do_kick;
    kick = 1'b1;
    cyc(1);
    kick = 1'b0;
  endtask

  // 0: sleep entry, 1: oscillator select change, 2: clock failure
  task automatic do_strobe(input int which);
    if (which == 0) sleep_enter = 1'b1;
    if (which == 1) osc_sel_chg = 1'b1;
    if (which == 2) clk_fail = 1'b1;
    cyc(1);
    sleep_enter = 1'b0;
    osc_sel_chg = 1'b0;
    clk_fail = 1'b0;
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    cyc(3);
    check(!wdt_rst && !wdt_wake && !win_open, "R1", "outputs in reset",
          int'({wdt_rst, wdt_wake, win_open}), 0);
    rst = 1'b0;
    measure(BP, 1'b0, "R1");
  endtask

  task automatic t_period(input int sel);
    period_sel = SW'(sel);
    do_reset();
    measure(BP << sel, 1'b0, "R3");
    period_sel = '0;
  endtask

  task automatic t_restart;
    do_reset();
    measure(BP, 1'b0, "R4");
    pulse_gone();
    measure(BP - 1, 1'b0, "R4");
  endtask

  task automatic t_window_flag;
    do_reset();
    cyc(23);
    check(win_open == 1'b0, "R5", "flag below 12", int'(win_open), 0);
    cyc(1);
    check(win_open == 1'b1, "R5", "flag at 12", int'(win_open), 1);
    cyc(7);
    check(win_open == 1'b1, "R5", "flag at 15", int'(win_open), 1);
    cyc(1);
    check(win_open == 1'b0 && wdt_rst, "R5", "flag after wrap", int'(win_open), 0);
  endtask

  task automatic t_kick_free;
    win_mode_n = 1'b1;
    do_reset();
    cyc(5);
    do_kick();
    check(!wdt_rst, "R8", "early kick without window", int'(wdt_rst), 0);
    measure(BP, 1'b0, "R8");
  endtask

  task automatic t_kick_early;
    win_mode_n = 1'b0;
    do_reset();
    cyc(23);
    do_kick();
    check(wdt_rst == 1'b1, "R7", "kick at count 11", int'(wdt_rst), 1);
    measure(BP, 1'b0, "R7");
    win_mode_n = 1'b1;
  endtask

  task automatic t_kick_late;
    win_mode_n = 1'b0;
    do_reset();
    cyc(24);
    do_kick();
    check(!wdt_rst && !win_open, "R8", "kick at count 12",
          int'({wdt_rst, win_open}), 0);
    measure(BP, 1'b0, "R8");
    win_mode_n = 1'b1;
  endtask

  task automatic t_sleep;
    do_reset();
    cyc(10);
    do_strobe(0);
    check(!wdt_rst && !wdt_wake, "R9", "sleep entry quiet", int'({wdt_rst, wdt_wake}), 0);
    measure(BP, 1'b1, "R9");
    pulse_gone();
    measure(BP - 1, 1'b0, "R9");
  endtask

  task automatic t_strobes;
    for (int w = 1; w <= 2; w++) begin
      do_reset();
      cyc(26);
      do_strobe(w);
      check(!wdt_rst && !win_open, "R6", "restart strobe clears",
            int'({wdt_rst, win_open}), 0);
      measure(BP, 1'b0, "R6");
    end
  endtask

  task automatic t_disabled;
    int seen = 0;
    int opened = 0;
    hw_en = 1'b0;
    sw_en = 1'b0;
    win_mode_n = 1'b0;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      if (i == 50) kick = 1'b1;
      cyc(1);
      kick = 1'b0;
      if (wdt_rst || wdt_wake) seen++;
      if (win_open) opened++;
    end
    check(seen == 0, "R2", "pulses while off", seen, 0);
    check(opened == 0, "R2", "window while off", opened, 0);
    win_mode_n = 1'b1;
    sw_en = 1'b1;
    measure(BP, 1'b0, "R2");
    sw_en = 1'b0;
    hw_en = 1'b1;
  endtask

  task automatic t_tick_gate;
    osc_tick = 1'b0;
    do_reset();
    cyc(100);
    check(!win_open && !wdt_rst, "R3", "no progress without tick",
          int'({win_open, wdt_rst}), 0);
    osc_tick = 1'b1;
    measure(BP, 1'b0, "R3");
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_period(0);
    t_period(1);
    t_period(3);
    t_restart();
    t_window_flag();
    t_kick_free();
    t_kick_early();
    t_kick_late();
    t_sleep();
    t_strobes();
    t_disabled();
    t_tick_gate();
    summary();
    $finish;
  end
endmodule